// File: doc/BRIEF.md
# DRAM Burst Access Sequencer

This block turns a stream of single-word memory requests into pin-level cycles for a multiplexed-address DRAM. It can also issue a plain one-clock access to another external space. Each request carries a 22-bit address, a write flag, write data and a space flag that marks it as DRAM or as the other space. For a DRAM request the sequencer drives the row part of the address while RAS falls, then the column part while CAS pulses. It also drives the read and write strobes and the outgoing data bus. Returned read data is presented on a response channel.

A row that has been opened stays open while DRAM requests to the same row keep arriving. Each further access then costs only a two-clock column cycle. A mode input decides what happens to an open row when the request stream stops or switches to the other space:
- With `ras_mode` = 0 (RAS released), the row is closed at once.
- With `ras_mode` = 1 (RAS held), the row is kept open, so the next same-row DRAM access skips the precharge and row cycles.

Requests follow valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the address, flags and data stable while `req_valid` is high and `req_ready` is low. The read response has no back-pressure: `rsp_valid` is high for exactly one clock, and the consumer must take `rsp_rdata` in that clock.

Top module: `dram_burst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, RAS and CAS are high, both strobes and the external select are high, `req_ready` is high and no row is open.
- R2: A DRAM request with no row open takes, in order:
  - one precharge clock with RAS high and the row field on the address bus;
  - one row clock with RAS low and the row field on the bus;
  - the two-clock column cycle.
- R3: A column cycle lasts two clocks:
  - First clock: the column field is on the bus and CAS is high.
  - Second clock: the bus is unchanged, CAS is low and the read strobe (read) or write strobe (write) is low.
  - CAS is low for exactly one clock per access.
  - For a write, the data is driven with the output enable high in both clocks.
- R4: A DRAM request to the row that is already open goes straight to the column cycle with RAS held low. A same-row request offered in the second column clock follows with no gap, so such bursts run at one access per two clocks.
- R5: A DRAM request to a different row while a row is open raises RAS for one precharge clock, then performs the row and column cycles for the new row.
- R6: With `ras_mode` = 0, an other-space access closes the open row, so RAS is high during that access. The next DRAM access again starts with the precharge and row clocks.
- R7: With `ras_mode` = 0, a clock in which the sequencer could take a request but none is offered closes the open row: RAS is high from the next clock.
- R8: With `ras_mode` = 1, an open row stays open (RAS low) across other-space accesses and idle clocks. A later request to that row goes straight to the column cycle.
- R9: An other-space access lasts one clock. In that clock the external select is low, the full 22-bit request address is on the bus, and the read strobe or write strobe is low according to the write flag.
- R10: For every read, `rsp_valid` is high for exactly the one clock after the strobing clock, and `rsp_rdata` holds the value that was on `mem_dq_in` during the strobing clock.
- R11: `req_ready` is high only:
  - when idle;
  - in the second column clock;
  - in an other-space clock.

  The column field is address bits [8:1] and the row field is bits [18:9] (default parameters). Each is placed on the low bits of the address bus, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_mode | input | 1 | 0: release the row on a pause or other-space access; 1: hold it open |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_dram | input | 1 | 1: DRAM space, 0: other external space |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 22 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock, no back-pressure |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 22 | Multiplexed address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ext_n | output | 1 | Other-space select, active low |
| mem_dq_out | output | 16 | Outgoing data |
| mem_dq_oe | output | 1 | Output enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Incoming data |

## Verification
The sequencer is driven with several kinds of request stream:
- Same-row runs offered back to back. These separate a true burst from a sequencer that reopens the row on every access.
- Row switches. These show that the precharge clock is inserted only when the row actually changes.
- Other-space accesses and idle gaps inside DRAM runs, repeated in both RAS modes. These tell the held-row behaviour apart from the released-row behaviour.
- A long pseudo-random mix that toggles the mode as it goes, with the requester holding its request through stalls. This covers mode changes at arbitrary points.

A behavioural model predicts every pin, `req_ready` and the read response in every clock. The boundary column and row values are included.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // bus cycle currently on the pins
  typedef enum logic [2:0] {
    PH_IDLE,  // nothing on the bus
    PH_PRE,   // precharge, row strobe high
    PH_ROW,   // row address strobed
    PH_COLA,  // column address setup
    PH_COLB,  // column strobe low, data strobe
    PH_EXT    // one-clock other-space access
  } phase_e;

  // what the multiplexed address bus carries
  typedef enum logic [1:0] {
    AS_NONE,
    AS_ROW,
    AS_COL,
    AS_FULL
  } addr_sel_e;

endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int ROW_LSB = 9,
  parameter int ROW_W   = 10,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 8
) (
  input  addr_sel_e         sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] bus
);

  localparam int ROW_TOP = ROW_LSB + ROW_W;
  localparam int COL_TOP = COL_LSB + COL_W;

  logic [ADDR_W-1:0] row_bus;
  logic [ADDR_W-1:0] col_bus;

  // place each field on the low bits of the bus, zeros above
  generate
    if (ROW_TOP <= ADDR_W && ROW_W < ADDR_W) begin : g_row
      assign row_bus = {{(ADDR_W-ROW_W){1'b0}}, addr[ROW_LSB +: ROW_W]};
    end else begin : g_row_full
      assign row_bus = addr;
    end
    if (COL_TOP <= ADDR_W && COL_W < ADDR_W) begin : g_col
      assign col_bus = {{(ADDR_W-COL_W){1'b0}}, addr[COL_LSB +: COL_W]};
    end else begin : g_col_full
      assign col_bus = addr;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      AS_ROW:  bus = row_bus;
      AS_COL:  bus = col_bus;
      AS_FULL: bus = addr;
      default: bus = '0;
    endcase
  end

endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int ROW_LSB = 9,
  parameter int ROW_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_mode,
  input  logic              req_valid,
  input  logic              req_dram,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output phase_e            phase,
  output logic              row_open,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);

  phase_e             phase_q, phase_d;
  logic               open_q, open_d;
  logic [ROW_W-1:0]   orow_q, orow_d;
  logic               cwr_q, cwr_d;
  logic [ADDR_W-1:0]  cadr_q, cadr_d;
  logic [DATA_W-1:0]  cdat_q, cdat_d;

  logic [ROW_W-1:0]   req_row;
  logic               slot_free;
  logic               take;
  logic               row_hit;

  assign req_row   = req_addr[ROW_LSB +: ROW_W];
  assign slot_free = (phase_q == PH_IDLE) || (phase_q == PH_COLB) || (phase_q == PH_EXT);
  assign take      = req_valid && slot_free;
  assign row_hit   = open_q && (orow_q == req_row);

  always_comb begin
    phase_d = phase_q;
    open_d  = open_q;
    orow_d  = orow_q;
    cwr_d   = cwr_q;
    cadr_d  = cadr_q;
    cdat_d  = cdat_q;
    unique case (phase_q)
      PH_PRE: begin
        phase_d = PH_ROW;
        open_d  = 1'b1;
      end
      PH_ROW:  phase_d = PH_COLA;
      PH_COLA: phase_d = PH_COLB;
      default: begin
        if (take) begin
          cwr_d  = req_write;
          cadr_d = req_addr;
          cdat_d = req_wdata;
          if (req_dram) begin
            if (row_hit) begin
              phase_d = PH_COLA;
            end else begin
              phase_d = PH_PRE;
              open_d  = 1'b0;
              orow_d  = req_row;
            end
          end else begin
            phase_d = PH_EXT;
            if (!ras_mode) open_d = 1'b0;
          end
        end else begin
          phase_d = PH_IDLE;
          if (!ras_mode) open_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      open_q  <= 1'b0;
      orow_q  <= '0;
      cwr_q   <= 1'b0;
      cadr_q  <= '0;
      cdat_q  <= '0;
    end else begin
      phase_q <= phase_d;
      open_q  <= open_d;
      orow_q  <= orow_d;
      cwr_q   <= cwr_d;
      cadr_q  <= cadr_d;
      cdat_q  <= cdat_d;
    end
  end

  assign req_ready = slot_free;
  assign phase     = phase_q;
  assign row_open  = open_q;
  assign cur_write = cwr_q;
  assign cur_addr  = cadr_q;
  assign cur_wdata = cdat_q;

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int ROW_LSB = 9,
  parameter int ROW_W   = 10,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              row_open,
  input  logic              cur_write,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic              mem_ext_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  addr_sel_e   sel;
  logic        strobe;
  logic        rv_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    unique case (phase)
      PH_PRE, PH_ROW:   sel = AS_ROW;
      PH_COLA, PH_COLB: sel = AS_COL;
      PH_EXT:           sel = AS_FULL;
      default:          sel = AS_NONE;
    endcase
  end

  dram_addr_mux #(
    .ADDR_W (ADDR_W),
    .ROW_LSB(ROW_LSB),
    .ROW_W  (ROW_W),
    .COL_LSB(COL_LSB),
    .COL_W  (COL_W)
  ) u_amux (
    .sel (sel),
    .addr(cur_addr),
    .bus (mem_addr)
  );

  assign strobe     = (phase == PH_COLB) || (phase == PH_EXT);
  assign mem_ras_n  = ~row_open;
  assign mem_cas_n  = (phase != PH_COLB);
  assign mem_ext_n  = (phase != PH_EXT);
  assign mem_rd_n   = ~(strobe && !cur_write);
  assign mem_we_n   = ~(strobe && cur_write);
  assign mem_dq_oe  = cur_write && ((phase == PH_COLA) || strobe);
  assign mem_dq_out = cur_wdata;

  // read data is captured at the end of the strobing clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= strobe && !cur_write;
      if (strobe && !cur_write) rd_q <= mem_dq_in;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 8,
  parameter int ROW_LSB = COL_LSB + COL_W,
  parameter int ROW_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dram,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic              mem_ext_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  phase_e            phase;
  logic              row_open;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  dram_row_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROW_LSB(ROW_LSB),
    .ROW_W  (ROW_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_mode (ras_mode),
    .req_valid(req_valid),
    .req_dram (req_dram),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .phase    (phase),
    .row_open (row_open),
    .cur_write(cur_write),
    .cur_addr (cur_addr),
    .cur_wdata(cur_wdata)
  );

  dram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROW_LSB(ROW_LSB),
    .ROW_W  (ROW_W),
    .COL_LSB(COL_LSB),
    .COL_W  (COL_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .row_open  (row_open),
    .cur_write (cur_write),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_rd_n  (mem_rd_n),
    .mem_we_n  (mem_we_n),
    .mem_ext_n (mem_ext_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/dram_seq_checks.sv
module dram_seq_checks #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_mode,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_rd_n,
  input logic              mem_we_n,
  input logic              mem_ext_n
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> mem_ras_n && mem_cas_n && req_ready); // R1
  AST_RAS_FALL_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> mem_cas_n && $past(mem_cas_n) && $past(mem_ext_n)); // R2
  AST_CAS_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) !mem_cas_n |=> mem_cas_n); // R3
  AST_COL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> $past(mem_cas_n) && $stable(mem_addr)); // R3
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n) !mem_cas_n |-> !mem_ras_n); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_rd_n, ~mem_we_n})); // R9
  AST_RAS_UP_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ext_n && !$past(ras_mode) |-> mem_ras_n); // R6
  AST_RAS_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ext_n && $past(ras_mode) && !$past(mem_ras_n) |-> !mem_ras_n); // R8
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mem_rd_n)); // R10
  AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> mem_ext_n && mem_cas_n); // R11

endmodule

bind dram_burst_seq dram_seq_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_mode (ras_mode),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n),
  .mem_rd_n (mem_rd_n),
  .mem_we_n (mem_we_n),
  .mem_ext_n(mem_ext_n)
);

// File: tb/sim_dram_burst_seq.sv
`timescale 1ns/1ps
module sim_dram_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_dram = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [21:0] mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_rd_n, mem_we_n, mem_ext_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  always #2.5 clk = ~clk;

  // memory returns a value derived from the address on the bus
  assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

  dram_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .ras_mode(ras_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_dram(req_dram),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n), .mem_ext_n(mem_ext_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct {
    bit ras; bit cas; bit ext; bit rd; bit we; bit oe; bit rsp;
    logic [21:0] addr; logic [15:0] wd;
    string tag; string rtag;
  } slot_t;

  typedef struct {
    bit v; bit dram; bit wr; bit mode;
    logic [21:0] a; logic [15:0] d;
  } offer_t;

  slot_t  q[$];
  offer_t plan_q[$];
  int total = 0, bad = 0;
  bit done = 0;
  bit pm = 0;
  bit row_open = 0;
  int open_row = 0;
  bit last_ext = 0;
  string closed_tag = "R2";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R11: row field = addr[18:9], column field = addr[8:1]
  function automatic int row_of(logic [21:0] a); return int'((a >> 9) & 22'h3FF); endfunction
  function automatic int col_of(logic [21:0] a); return int'((a >> 1) & 22'hFF); endfunction

  // kinds: 0 idle, 1 precharge, 2 row, 3 col setup, 4 col strobe, 5 other space
  function automatic slot_t mk(int k, logic [21:0] a, bit wr, logic [15:0] d, bit ras,
                               string tag, string rtag);
    slot_t s;
    bit stb;
    stb    = (k == 4) || (k == 5);
    s.ras  = ras;
    s.cas  = (k != 4);
    s.ext  = (k != 5);
    s.rd   = !(stb && !wr);
    s.we   = !(stb && wr);
    s.oe   = wr && (k == 3 || k == 4 || k == 5);
    s.rsp  = stb && !wr;
    s.wd   = d;
    if (k == 1 || k == 2) s.addr = 22'(row_of(a));
    else if (k == 3 || k == 4) s.addr = 22'(col_of(a));
    else if (k == 5) s.addr = a;
    else s.addr = '0;
    s.tag  = tag;
    s.rtag = rtag;
    return s;
  endfunction

  task automatic add_d(int r, int c, bit wr, logic [15:0] d);
    offer_t o;
    o.v = 1; o.dram = 1; o.wr = wr; o.mode = pm; o.d = d;
    o.a = 22'((r << 9) | (c << 1));
    plan_q.push_back(o);
  endtask

  task automatic add_x(logic [21:0] a, bit wr, logic [15:0] d);
    offer_t o;
    o.v = 1; o.dram = 0; o.wr = wr; o.mode = pm; o.a = a; o.d = d;
    plan_q.push_back(o);
  endtask

  task automatic add_gap(int n);
    for (int i = 0; i < n; i++) begin
      offer_t o;
      o.v = 0; o.dram = 0; o.wr = 0; o.mode = pm; o.a = '0; o.d = '0;
      plan_q.push_back(o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit prev_rsp;
    logic [15:0] prev_data;
    int tail;
    int unsigned lf;
    slot_t ex;
    offer_t o;
    bit ready_m, acc;
    int r;
    string t;

    // directed stream, RAS released
    pm = 0;
    add_d(5, 1, 0, 16'h0);
    add_d(5, 2, 1, 16'hBEEF);
    add_d(5, 3, 0, 16'h0);
    add_x(22'h3F0F10, 1, 16'h1234);
    add_d(5, 4, 0, 16'h0);
    add_gap(2);
    add_d(5, 5, 1, 16'h0F0F);
    add_d(9, 6, 0, 16'h0);
    add_d(9, 255, 1, 16'hFFFF);
    add_x(22'h2AAAAA, 0, 16'h0);
    // RAS held
    pm = 1;
    add_d(9, 7, 0, 16'h0);
    add_x(22'h155555, 0, 16'h0);
    add_d(9, 8, 1, 16'hA001);
    add_gap(3);
    add_d(9, 9, 0, 16'h0);
    add_d(1023, 0, 0, 16'h0);
    add_x(22'h000001, 1, 16'h7777);
    add_d(3, 128, 1, 16'h4242);
    pm = 0;
    add_gap(1);
    add_d(3, 129, 0, 16'h0);
    // pseudo-random mix
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 160; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[11:8] == 4'd0) pm = ~pm;
      case (lf % 6)
        0, 1, 2: add_d(int'(lf[17:16]) + 2, int'(lf[27:20]), lf[4], lf[31:16]);
        3:       add_x(lf[21:0], lf[5], lf[15:0]);
        4:       add_d(int'(lf[25:16]), int'(lf[7:0]), lf[6], lf[15:0]);
        default: add_gap(int'(lf[13:12]) + 1);
      endcase
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset ras_n", mem_ras_n, 1);
    chk("R1", "reset cas_n", mem_cas_n, 1);
    chk("R1", "reset rd_n", mem_rd_n, 1);
    chk("R1", "reset we_n", mem_we_n, 1);
    chk("R1", "reset ext_n", mem_ext_n, 1);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;

    prev_rsp = 0;
    prev_data = '0;
    tail = 0;
    forever begin
      @(negedge clk);
      // compare the cycle now on the pins
      if (q.size() != 0) ex = q[0];
      else ex = mk(0, '0, 0, '0, !row_open, row_open ? "R8" : "R7", row_open ? "R8" : "R7");
      chk(ex.rtag, "ras_n", mem_ras_n, ex.ras);
      chk(ex.tag, "cas_n", mem_cas_n, ex.cas);
      chk(ex.tag, "ext_n", mem_ext_n, ex.ext);
      chk(ex.tag, "rd_n", mem_rd_n, ex.rd);
      chk(ex.tag, "we_n", mem_we_n, ex.we);
      chk(ex.tag, "dq_oe", mem_dq_oe, ex.oe);
      chk(ex.tag, "addr", mem_addr, ex.addr);
      if (ex.oe) chk(ex.tag, "dq_out", mem_dq_out, ex.wd);
      chk("R11", "ready", req_ready, q.size() <= 1);
      chk("R10", "rsp_valid", rsp_valid, prev_rsp);
      if (prev_rsp) chk("R10", "rsp_rdata", rsp_rdata, prev_data);
      prev_rsp  = ex.rsp;
      prev_data = ex.addr[15:0] ^ 16'h5A3C;

      // drive the next offer
      if (plan_q.size() != 0) o = plan_q[0];
      else begin
        o.v = 0; o.dram = 0; o.wr = 0; o.mode = pm; o.a = '0; o.d = '0;
      end
      req_valid = o.v; req_dram = o.dram; req_write = o.wr;
      req_addr = o.a; req_wdata = o.d; ras_mode = o.mode;

      // model the coming edge
      ready_m = (q.size() <= 1);
      acc = o.v && ready_m;
      if (plan_q.size() != 0 && (acc || !o.v)) void'(plan_q.pop_front());
      if (q.size() != 0) void'(q.pop_front());
      if (acc) begin
        if (o.dram) begin
          r = row_of(o.a);
          if (row_open && r == open_row) begin
            t = last_ext ? "R8" : "R4";
            q.push_back(mk(3, o.a, o.wr, o.d, 0, t, t));
            q.push_back(mk(4, o.a, o.wr, o.d, 0, t, t));
          end else begin
            t = row_open ? "R5" : closed_tag;
            q.push_back(mk(1, o.a, o.wr, o.d, 1, t, t));
            q.push_back(mk(2, o.a, o.wr, o.d, 0, t, t));
            q.push_back(mk(3, o.a, o.wr, o.d, 0, "R3", t));
            q.push_back(mk(4, o.a, o.wr, o.d, 0, "R3", t));
            row_open = 1;
            open_row = r;
          end
          last_ext = 0;
        end else begin
          if (!o.mode) begin
            if (row_open) closed_tag = "R6";
            row_open = 0;
          end
          q.push_back(mk(5, o.a, o.wr, o.d, !row_open, "R9", o.mode ? "R8" : "R6"));
          last_ext = 1;
        end
      end else if (q.size() == 0 && !o.mode) begin
        if (row_open) closed_tag = "R7";
        row_open = 0;
      end

      if (plan_q.size() == 0 && q.size() == 0) tail++;
      if (tail > 3) break;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule